// File: doc/BRIEF.md
# SSI Absolute Position Transmitter

This block is the slave side of a synchronous serial interface (SSI) link that reports an absolute position. When an external master pulls its serial clock low after an idle period, the block takes a snapshot of a multiturn count, a singleturn angle and an error flag, builds one frame from them, and shifts that frame out MSB first. It presents one bit on each rising edge of the master clock. Configuration inputs set the frame layout: the singleturn width, how many multiturn bits go in front of it, Gray or binary coding of the position word, and whether an error bit ends the frame.

When the frame is complete, the data line is held low for a monoflop timeout. The timeout is counted in internal ticks, and each tick is `TICK_DIV` cycles of the core clock. A clock edge from the master during the timeout starts the count again. When the timeout runs out, the line returns high and the block can accept a new frame. The master clock arrives without any relation to the core clock. It is synchronized inside the block and must run at no more than a quarter of the core clock rate.

Top module: `ssi_pos_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `sdo` is 1.
- R2: The first falling edge of `ssi_clk` while the block is idle captures `mt_pos`, `st_pos` and `pos_err`. Changes to these inputs after that edge do not alter the frame in progress.
- R3: Each rising edge of `ssi_clk` after the capture drives the next frame bit onto `sdo`, starting with the first bit of the frame. The multiturn bits come first, MSB first, followed by the singleturn bits, MSB first.
- R4: The singleturn width is 8 + `cfg_st_len`. Codes above `ST_MAX_W`-8 (25 with the defaults) are clamped to `ST_MAX_W` bits (33).
- R5: `cfg_mt_mode` selects how many multiturn bits are sent: 0 sends none, 1 sends the low 4 bits, 2 sends the low 8 bits, and 3 sends all `MT_W` bits (16).
- R6: The part of the frame after the multiturn bits is max(13, singleturn width + `cfg_err_en`) bits long. Zero bits fill the gap between the last singleturn bit and the error bit (or the end of the frame). The frame length is the multiturn bit count plus this section length.
- R7: When `cfg_err_en` is 1, the captured error flag is the last bit of the frame. When `cfg_err_en` is 0, no error bit is sent.
- R8: When `cfg_gray` is 1, the combined multiturn-and-singleturn word is sent in Gray code (g = b xor (b >> 1) over the whole word). The padding zeros and the error bit are never encoded.
- R9: The first rising edge after the last frame bit drives `sdo` to 0. `sdo` stays 0 until the timeout expires.
- R10: `cfg_tmo_sel` selects a timeout of N ticks: 00 gives 32, 01 gives 16, 10 gives 4 and 11 gives 2. The line returns to 1 between N-1 and N ticks (plus the synchronizer latency) after the last clock edge.
- R11: Any `ssi_clk` edge during the timeout restarts the count, and `sdo` stays 0.
- R12: If the master stops mid-frame for longer than the timeout, the block returns to idle. The next falling edge starts a fresh frame from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ssi_clk | input | 1 | Serial clock from the master; idles high; asynchronous to `clk` |
| cfg_tmo_sel | input | 2 | Timeout length select |
| cfg_st_len | input | 5 | Singleturn width code (width = 8 + code) |
| cfg_mt_mode | input | 2 | Multiturn prefix width select |
| cfg_gray | input | 1 | 1 = Gray-code the position word |
| cfg_err_en | input | 1 | 1 = append the error bit |
| mt_pos | input | MT_W | Multiturn count |
| st_pos | input | ST_MAX_W | Singleturn angle, right-aligned |
| pos_err | input | 1 | Error flag |
| sdo | output | 1 | Serial data out |

## Verification
The assertions assume that `ssi_clk` toggles more slowly than the synchronizer can follow. They also assume that the configuration inputs do not change while a frame is in flight, so that the captured frame length and the timeout select describe the frame being sent. The stimulus keeps to this: the master clock has a half period of 6 core cycles, which is shorter than one timeout tick, and configuration changes only while the line is idle. The only inputs that change during a frame are the position inputs, and they are changed on purpose to show that the capture at the falling edge holds.

// File: rtl/ssi_pkg.sv
// Shared types and helpers for the SSI position transmitter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ssi_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_HOLD  = 2'd2
    } tx_state_t;

    // Number of ticks that make up the monoflop for each select code.
    function automatic logic [5:0] tmo_ticks(input logic [1:0] sel);
        case (sel)
            2'b00:   return 6'd32;
            2'b01:   return 6'd16;
            2'b10:   return 6'd4;
            default: return 6'd2;
        endcase
    endfunction

endpackage

// File: rtl/ssi_edge_det.sv
// Brings the external serial clock into the core clock domain and flags
// its edges. Assumes the serial clock is at most a quarter of the core rate.
// The chain resets high to match the idle level of the line, so no edge is
// seen on release from reset.
module ssi_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ssi_clk_i,
    output logic rise_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchronizer chain plus one register that holds the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ssi_clk_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Edge pulses, one core cycle wide.
    always_comb begin
        rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
        fall_o = ~sync_q[SYNC_STAGES-1] & prev_q;
    end

endmodule

// File: rtl/ssi_frame_build.sv
// Combinational frame assembly. The output frame is left-aligned: bit
// FRM_W-1 is sent first. The frame holds the multiturn prefix, then the
// singleturn field, then zero padding, then the optional error bit.
// Gray coding covers only the position word. Assumes the caller keeps
// cfg stable while a frame is latched.
module ssi_frame_build
    import ssi_pkg::*;
#(
    parameter int MT_W     = 16,
    parameter int ST_MAX_W = 33,
    parameter int FRM_W    = 50,
    parameter int LEN_W    = 6
) (
    input  logic [1:0]          cfg_st_mode_unused_guard,
    input  logic [4:0]          cfg_st_len,
    input  logic [1:0]          cfg_mt_mode,
    input  logic                cfg_gray,
    input  logic                cfg_err_en,
    input  logic [MT_W-1:0]     mt_pos,
    input  logic [ST_MAX_W-1:0] st_pos,
    input  logic                pos_err,
    output logic [FRM_W-1:0]    frame_o,
    output logic [LEN_W-1:0]    frame_len_o
);
    localparam int MIN_SECT = 13;

    int   st_w, n_mt, word_len, sect, total;
    logic bin_bit, prev_bit;

    // Resolve the field widths from the configuration codes.
    always_comb begin
        st_w = 8 + int'(cfg_st_len);
        if (st_w > ST_MAX_W) st_w = ST_MAX_W;
        case (cfg_mt_mode)
            2'b00:   n_mt = 0;
            2'b01:   n_mt = (MT_W < 4) ? MT_W : 4;
            2'b10:   n_mt = (MT_W < 8) ? MT_W : 8;
            default: n_mt = MT_W;
        endcase
        word_len = n_mt + st_w;
        sect     = st_w + (cfg_err_en ? 1 : 0);
        if (sect < MIN_SECT) sect = MIN_SECT;
        total    = n_mt + sect;
        frame_len_o = LEN_W'(total);
    end

    // Walk the frame from first to last bit and place each one.
    always_comb begin
        frame_o  = '0;
        prev_bit = 1'b0;
        for (int p = 0; p < FRM_W; p++) begin
            bin_bit = 1'b0;
            if (p < n_mt)
                bin_bit = mt_pos[n_mt-1-p];
            else if (p < word_len)
                bin_bit = st_pos[st_w-1-(p-n_mt)];
            if (p < word_len)
                frame_o[FRM_W-1-p] = cfg_gray ? (bin_bit ^ prev_bit) : bin_bit;
            else if (cfg_err_en && (p == total - 1))
                frame_o[FRM_W-1-p] = pos_err;
            prev_bit = bin_bit;
        end
    end

endmodule

// File: rtl/ssi_monoflop.sv
// Idle timeout counter. A free-running prescaler makes one tick every
// TICK_DIV core cycles. The counter counts ticks while run_i is high and
// is cleared by restart_i. expire_o rises once the selected tick count is
// reached with no restart in between. Because the prescaler free-runs,
// the timeout lands between N-1 and N full ticks after the last restart.
module ssi_monoflop
    import ssi_pkg::*;
#(
    parameter int TICK_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic [1:0] tmo_sel,
    output logic       expire_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0] pre_q;
    logic          tick;
    logic [5:0]    cnt_q;
    logic [5:0]    limit;

    assign tick  = (pre_q == PW'(TICK_DIV - 1));
    assign limit = tmo_ticks(tmo_sel);

    // Free-running prescaler that sets the tick period.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end

    // Tick counter, cleared by any line edge or when not armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || restart_i) cnt_q <= '0;
        else if (tick && cnt_q != limit)   cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = run_i && !restart_i && (cnt_q == limit);

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 6'd32); // R10
    AST_CLEAR_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && restart_i) |=> (cnt_q == 6'd0)); // R11

endmodule

// File: rtl/ssi_pos_tx.sv
// SSI slave transmitter, top level. It waits idle with the line high. On
// the first falling serial-clock edge it latches the assembled frame, then
// moves one bit out per rising edge. After the last bit it holds the line
// low until the monoflop expires. Assumes ssi_clk runs at most a quarter
// of the clk rate and that configuration changes only while idle.
module ssi_pos_tx
    import ssi_pkg::*;
#(
    parameter int MT_W        = 16,
    parameter int ST_MAX_W    = 33,
    parameter int TICK_DIV    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ssi_clk,
    input  logic [1:0]          cfg_tmo_sel,
    input  logic [4:0]          cfg_st_len,
    input  logic [1:0]          cfg_mt_mode,
    input  logic                cfg_gray,
    input  logic                cfg_err_en,
    input  logic [MT_W-1:0]     mt_pos,
    input  logic [ST_MAX_W-1:0] st_pos,
    input  logic                pos_err,
    output logic                sdo
);
    localparam int SECT_MAX = (ST_MAX_W + 1 > 13) ? ST_MAX_W + 1 : 13;
    localparam int FRM_W    = MT_W + SECT_MAX;
    localparam int LEN_W    = $clog2(FRM_W + 1);

    logic             rise, fall, expire;
    logic [FRM_W-1:0] frame;
    logic [LEN_W-1:0] frame_len;
    tx_state_t        state_q;
    logic [FRM_W-1:0] shreg_q;
    logic [LEN_W-1:0] bits_left_q;
    logic             sdo_q;

    ssi_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ssi_clk_i (ssi_clk),
        .rise_o    (rise),
        .fall_o    (fall)
    );

    ssi_frame_build #(
        .MT_W     (MT_W),
        .ST_MAX_W (ST_MAX_W),
        .FRM_W    (FRM_W),
        .LEN_W    (LEN_W)
    ) u_build (
        .cfg_st_mode_unused_guard (cfg_tmo_sel),
        .cfg_st_len  (cfg_st_len),
        .cfg_mt_mode (cfg_mt_mode),
        .cfg_gray    (cfg_gray),
        .cfg_err_en  (cfg_err_en),
        .mt_pos      (mt_pos),
        .st_pos      (st_pos),
        .pos_err     (pos_err),
        .frame_o     (frame),
        .frame_len_o (frame_len)
    );

    ssi_monoflop #(.TICK_DIV(TICK_DIV)) u_mono (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q != TX_IDLE),
        .restart_i (rise | fall),
        .tmo_sel   (cfg_tmo_sel),
        .expire_o  (expire)
    );

    // Transfer sequencer: latch on fall, shift on rise, hold until timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= TX_IDLE;
            shreg_q     <= '0;
            bits_left_q <= '0;
            sdo_q       <= 1'b1;
        end else begin
            case (state_q)
                TX_IDLE: begin
                    sdo_q <= 1'b1;
                    if (fall) begin
                        shreg_q     <= frame;
                        bits_left_q <= frame_len;
                        state_q     <= TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (expire) begin
                        state_q <= TX_IDLE;
                        sdo_q   <= 1'b1;
                    end else if (rise) begin
                        if (bits_left_q != '0) begin
                            sdo_q       <= shreg_q[FRM_W-1];
                            shreg_q     <= {shreg_q[FRM_W-2:0], 1'b0};
                            bits_left_q <= bits_left_q - 1'b1;
                        end else begin
                            sdo_q   <= 1'b0;
                            state_q <= TX_HOLD;
                        end
                    end
                end
                default: begin
                    sdo_q <= 1'b0;
                    if (expire) begin
                        state_q <= TX_IDLE;
                        sdo_q   <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign sdo = sdo_q;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && $past(state_q == TX_IDLE)) |-> sdo_q); // R1
    AST_LATCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SHIFT && $past(state_q == TX_IDLE)) |-> $past(fall)); // R2
    AST_FRAME_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_len >= LEN_W'(13)) && (frame_len <= LEN_W'(FRM_W))); // R6
    AST_HOLD_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_HOLD) |-> !sdo_q); // R9
    AST_HOLD_AFTER_ALL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == TX_HOLD) |-> (bits_left_q == '0)); // R9

endmodule

// File: tb/ssi_pos_tx_test.sv
// Self-checking bench: a table of frame vectors, then directed tests.
module ssi_pos_tx_test;
    localparam int MT_W     = 16;
    localparam int ST_MAX_W = 33;
    localparam int TICK_DIV = 8;
    localparam int HALF     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ssi_clk = 1'b1;
    logic [1:0] cfg_tmo_sel = '0;
    logic [4:0] cfg_st_len = '0;
    logic [1:0] cfg_mt_mode = '0;
    logic cfg_gray = 1'b0, cfg_err_en = 1'b0;
    logic [MT_W-1:0] mt_pos = '0;
    logic [ST_MAX_W-1:0] st_pos = '0;
    logic pos_err = 1'b0;
    logic sdo;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk; // 50 MHz

    ssi_pos_tx #(.MT_W(MT_W), .ST_MAX_W(ST_MAX_W), .TICK_DIV(TICK_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .ssi_clk(ssi_clk),
        .cfg_tmo_sel(cfg_tmo_sel), .cfg_st_len(cfg_st_len),
        .cfg_mt_mode(cfg_mt_mode), .cfg_gray(cfg_gray),
        .cfg_err_en(cfg_err_en), .mt_pos(mt_pos), .st_pos(st_pos),
        .pos_err(pos_err), .sdo(sdo)
    );

    // Fields: tmo[60:59] code[58:54] mode[53:52] gray[51] err_en[50] err[49] mt[48:33] st[32:0]
    localparam logic [60:0] VEC [0:7] = '{
        {2'd3, 5'd0,  2'd0, 1'b0, 1'b1, 1'b1, 16'h0000, 33'h0_0000_00A5},
        {2'd2, 5'd5,  2'd1, 1'b1, 1'b1, 1'b0, 16'h1234, 33'h0_0000_1ABC},
        {2'd1, 5'd17, 2'd2, 1'b0, 1'b0, 1'b0, 16'hBEEF, 33'h0_01A5_5A5A},
        {2'd0, 5'd25, 2'd3, 1'b1, 1'b1, 1'b1, 16'hC3A5, 33'h1_2345_6789},
        {2'd3, 5'd3,  2'd3, 1'b1, 1'b1, 1'b1, 16'h8001, 33'h0_0000_05F3},
        {2'd2, 5'd4,  2'd0, 1'b0, 1'b1, 1'b1, 16'hFFFF, 33'h0_0000_0F0F},
        {2'd1, 5'd2,  2'd1, 1'b1, 1'b0, 1'b0, 16'h000B, 33'h0_0000_02D9},
        {2'd3, 5'd31, 2'd2, 1'b0, 1'b1, 1'b0, 16'h00C6, 33'h1_F00F_A55A}
    };

    function automatic int ticks_of(input logic [1:0] s);
        case (s) 2'd0: return 32; 2'd1: return 16; 2'd2: return 4; default: return 2; endcase
    endfunction

    // Expected frame, right-aligned; the first bit sent is bit len-1.
    function automatic logic [63:0] exp_frame(input logic [4:0] code, input logic [1:0] mode,
            input logic gray, input logic een, input logic err,
            input logic [15:0] mt, input logic [32:0] st, output int len);
        int stw, nmt, sect;
        logic [63:0] w, mtv, stv;
        stw = 8 + int'(code);
        if (stw > 33) stw = 33;
        nmt = (mode == 2'd0) ? 0 : (mode == 2'd1) ? 4 : (mode == 2'd2) ? 8 : 16;
        mtv = {48'd0, mt} & ((64'd1 << nmt) - 64'd1);
        stv = {31'd0, st} & ((64'd1 << stw) - 64'd1);
        w = (mtv << stw) | stv;
        if (gray) w = w ^ (w >> 1);
        sect = (stw + int'(een) < 13) ? 13 : stw + int'(een);
        len = nmt + sect;
        return (w << (sect - stw)) | {63'd0, een & err};
    endfunction

    task automatic check(input logic cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ssi_set(input logic v);
        ssi_clk = v;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic load(input logic [60:0] v);
        cfg_tmo_sel = v[60:59]; cfg_st_len = v[58:54]; cfg_mt_mode = v[53:52];
        cfg_gray = v[51]; cfg_err_en = v[50]; pos_err = v[49];
        mt_pos = v[48:33]; st_pos = v[32:0];
        repeat (2) @(negedge clk);
    endtask

    // One full frame from the current inputs; inputs are scrambled after capture.
    task automatic run_frame(input string tag);
        int len, n;
        logic [63:0] exp, got;
        exp = exp_frame(cfg_st_len, cfg_mt_mode, cfg_gray, cfg_err_en, pos_err, mt_pos, st_pos, len);
        n = ticks_of(cfg_tmo_sel);
        got = '0;
        ssi_set(1'b0);
        mt_pos = ~mt_pos; st_pos = ~st_pos; pos_err = ~pos_err; // R2: must not matter
        for (int k = 0; k < len; k++) begin
            ssi_set(1'b1);
            got = {got[62:0], sdo};
            ssi_set(1'b0);
        end
        check(got == exp, {tag, " R2/R3/R4/R5/R6/R7/R8 frame"}, got, exp);
        ssi_set(1'b1);
        check(sdo == 1'b0, {tag, " R9 line low after last bit"}, {63'd0, sdo}, 64'd0);
        repeat ((n - 1) * TICK_DIV - HALF) @(negedge clk);
        check(sdo == 1'b0, {tag, " R10 still low before timeout"}, {63'd0, sdo}, 64'd0);
        repeat (TICK_DIV + 10) @(negedge clk);
        check(sdo == 1'b1, {tag, " R10 high after timeout"}, {63'd0, sdo}, 64'd1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(sdo == 1'b1, "R1 line high in reset", {63'd0, sdo}, 64'd1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sdo == 1'b1, "R1 line high when idle", {63'd0, sdo}, 64'd1);

        // Vector table walk.
        for (int i = 0; i < 8; i++) begin
            load(VEC[i]);
            run_frame($sformatf("vec%0d", i));
        end

        // R11: edges during the hold window restart the timeout (32 ticks = 256 cycles).
        load(VEC[3]);
        run_frame("r11_pre");
        load(VEC[3]);
        begin
            int len;
            logic [63:0] e;
            e = exp_frame(cfg_st_len, cfg_mt_mode, cfg_gray, cfg_err_en, pos_err, mt_pos, st_pos, len);
            ssi_set(1'b0);
            for (int k = 0; k < len + 1; k++) begin ssi_set(1'b1); ssi_set(1'b0); end
            for (int k = 0; k < 5; k++) begin
                repeat (100) @(negedge clk);
                ssi_set(1'b1);
                ssi_set(1'b0);
            end
            ssi_set(1'b1);
            check(sdo == 1'b0, "R11 restart keeps line low", {63'd0, sdo}, 64'd0);
            repeat (32 * TICK_DIV + 10) @(negedge clk);
            check(sdo == 1'b1, "R11 high after quiet timeout", {63'd0, sdo}, 64'd1);
        end

        // R12: abort after two bits, then a fresh frame starts from its first bit.
        load(VEC[0]);
        ssi_set(1'b0);
        ssi_set(1'b1); ssi_set(1'b0); ssi_set(1'b1);
        repeat (2 * TICK_DIV + 10) @(negedge clk);
        check(sdo == 1'b1, "R12 idle after mid-frame stall", {63'd0, sdo}, 64'd1);
        load(VEC[0]);
        run_frame("R12 fresh");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule